// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block sits at the end of a 512-bit vector execution pipe. It takes the vector produced by the arithmetic, the previous contents of the destination register, and a predicate held in one of eight 64-bit predicate registers. From these it forms the vector that is written back. The element size is chosen per operation: 8, 16, 32 or 64 bits. Each predicate bit governs one element. An enabled element receives the new result. A disabled element either keeps the old destination value or is cleared, as a per-operation control bit selects. Selecting predicate register 0 turns predication off entirely.

The same block also provides the operand-side broadcast. It is a combinational path that either passes a full source vector to the arithmetic or fills every element with a scalar taken from the low bits of a 64-bit input. The predicate register file has one write port and one internal read port, and that read port feeds the writeback select. The writeback result is registered, with a valid flag and no backpressure.

Top module: `mask_writeback`

## Requirements
- R1: While reset is asserted and immediately after it, `out_valid` is 0 and `out_data` is all zeros. Reset clears all eight predicate registers to zero.
- R2: The element size code on `lane_sz` is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit elements. Element i occupies bits [i*W +: W]. When predicate bit i is 1, element i of the written vector equals element i of `result`.
- R3: When `zero_mode` is 0, an element whose predicate bit is 0 equals the same element of `old_dst`.
- R4: When `zero_mode` is 1, an element whose predicate bit is 0 is all zeros.
- R5: When `mask_sel` is 0, every element takes `result`, whatever has been written into predicate register 0.
- R6: Predicate bits at or above the element count (64, 32, 16 or 8) have no effect on the written vector.
- R7: An operation presented with `in_valid` high appears on `out_data` one clock later, with `out_valid` high. `out_valid` is low one clock after a cycle with `in_valid` low, and `out_data` then keeps its previous value.
- R8: A write with `mk_we` high stores `mk_wdata` into register `mk_waddr` at the clock edge. An operation in the same cycle that selects that register uses the value from before the write. Operations in later cycles use the new value.
- R9: `opnd_vec` is combinational. With `bcast_en` low it equals `src_vec`. With `bcast_en` high, every element of the selected size equals the low element-size bits of `bcast_scalar`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| result | input | 512 | Vector computed by the arithmetic |
| old_dst | input | 512 | Previous destination contents |
| lane_sz | input | 2 | Element size code (0:8, 1:16, 2:32, 3:64 bits) |
| zero_mode | input | 1 | 1 clears disabled elements, 0 keeps old ones |
| mask_sel | input | 3 | Predicate register select, 0 disables predication |
| mk_we | input | 1 | Predicate register write enable |
| mk_waddr | input | 3 | Predicate register write index |
| mk_wdata | input | 64 | Predicate register write data |
| bcast_en | input | 1 | Replace source vector by replicated scalar |
| bcast_scalar | input | 64 | Scalar to broadcast (low bits used) |
| src_vec | input | 512 | Full vector source operand |
| opnd_vec | output | 512 | Operand vector toward the arithmetic |
| out_valid | output | 1 | Written vector valid |
| out_data | output | 512 | Vector to write back |

## Verification
On every cycle, the assertions check the one-cycle valid latency and the hold of `out_data` in idle cycles. They also check three whole-vector cases: predication off gives the result, an all-clear predicate in merge mode gives the old destination, and an all-clear predicate in zero mode gives zeros. The low broadcast element is checked against the scalar on every cycle. Only the bench scenarios can show the per-element mapping of predicate bits at each element size, and that high predicate bits are ignored. The same holds for the read-before-write order of the predicate registers, the irrelevance of register 0's contents, and full-width replication of the broadcast scalar.

// File: rtl/mask_writeback.sv
module mask_writeback #(
  parameter int VW = 512,
  parameter int NK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VW-1:0]     result,
  input  logic [VW-1:0]     old_dst,
  input  logic [1:0]        lane_sz,
  input  logic              zero_mode,
  input  logic [2:0]        mask_sel,
  input  logic              mk_we,
  input  logic [2:0]        mk_waddr,
  input  logic [VW/8-1:0]   mk_wdata,
  input  logic              bcast_en,
  input  logic [63:0]       bcast_scalar,
  input  logic [VW-1:0]     src_vec,
  output logic [VW-1:0]     opnd_vec,
  output logic              out_valid,
  output logic [VW-1:0]     out_data
);
  localparam int NB = VW / 8;
  localparam int BW = $clog2(NB);

  logic [NB-1:0] kreg [NK];
  logic [NB-1:0] sel_mask;
  logic [NB-1:0] byte_en;
  logic [VW-1:0] merged;

  assign sel_mask = (mask_sel == 3'd0) ? '1 : kreg[mask_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) kreg[k] <= '0;
    end else if (mk_we) begin
      kreg[mk_waddr] <= mk_wdata;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [2:0] sub;
    assign byte_en[b] = sel_mask[BW'(b) >> lane_sz];
    assign merged[b*8 +: 8] = byte_en[b] ? result[b*8 +: 8]
                            : (zero_mode ? 8'h00 : old_dst[b*8 +: 8]);
    assign sub = 3'(b) & ((3'd1 << lane_sz) - 3'd1);
    assign opnd_vec[b*8 +: 8] = bcast_en ? bcast_scalar[{sub, 3'b000} +: 8]
                                         : src_vec[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= merged;
    end
  end

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  p_nomask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_sel == 3'd0) |=> (out_data == $past(result)));
  p_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero_mode && sel_mask == '0) |=> (out_data == $past(old_dst)));
  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_mode && sel_mask == '0) |=> (out_data == '0));
  p_bcast_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_en |-> (opnd_vec[7:0] == bcast_scalar[7:0]));
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_data == '0));
endmodule

// File: tb/tb_mask_writeback.sv
module tb_mask_writeback;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, zero_mode = 0, mk_we = 0, bcast_en = 0;
  logic [511:0] result = '0, old_dst = '0, src_vec = '0, opnd_vec, out_data;
  logic [1:0] lane_sz = 0;
  logic [2:0] mask_sel = 0, mk_waddr = 0;
  logic [63:0] mk_wdata = 0, bcast_scalar = 0;
  logic out_valid;

  int tests = 0, fails = 0;
  string cur = "R1";
  bit done = 0;

  logic [63:0] m_k [8];
  logic m_valid;
  logic [511:0] m_data;

  always #5 clk = ~clk;

  mask_writeback dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .result(result),
    .old_dst(old_dst), .lane_sz(lane_sz), .zero_mode(zero_mode), .mask_sel(mask_sel),
    .mk_we(mk_we), .mk_waddr(mk_waddr), .mk_wdata(mk_wdata), .bcast_en(bcast_en),
    .bcast_scalar(bcast_scalar), .src_vec(src_vec), .opnd_vec(opnd_vec),
    .out_valid(out_valid), .out_data(out_data));

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] ref_wb(logic [511:0] res, logic [511:0] old,
      int sz, bit zm, logic [63:0] m);
    logic [511:0] v;
    int ebytes = 1 << sz;
    for (int i = 0; i < 64; i++) begin
      int lane = i / ebytes;
      if (m[lane]) v[i*8 +: 8] = res[i*8 +: 8];
      else if (zm) v[i*8 +: 8] = 8'h00;
      else v[i*8 +: 8] = old[i*8 +: 8];
    end
    return v;
  endfunction

  function automatic logic [511:0] ref_bc(logic [63:0] s, int sz);
    logic [511:0] v;
    int ebytes = 1 << sz;
    for (int i = 0; i < 64; i++) v[i*8 +: 8] = s[(i % ebytes)*8 +: 8];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0;
      m_data  <= '0;
      for (int k = 0; k < 8; k++) m_k[k] <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid)
        m_data <= ref_wb(result, old_dst, lane_sz, zero_mode,
                         (mask_sel == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : m_k[mask_sel]);
      if (mk_we) m_k[mk_waddr] <= mk_wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (out_valid !== m_valid || out_data !== m_data) begin
        fails++;
        $display("FAIL %s: out_valid=%0b data=%h expected valid=%0b data=%h",
                 cur, out_valid, out_data, m_valid, m_data);
      end
    end
  end

  task automatic op(input int sz, input bit zm, input int ks);
    @(negedge clk);
    in_valid = 1; lane_sz = 2'(sz); zero_mode = zm; mask_sel = 3'(ks);
    result = rnd512(); old_dst = rnd512();
  endtask

  task automatic kwrite(input int a, input logic [63:0] d);
    @(negedge clk);
    in_valid = 0; mk_we = 1; mk_waddr = 3'(a); mk_wdata = d;
    @(negedge clk);
    mk_we = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; mk_we = 0;
  endtask

  task automatic chk_bc(input int sz, input bit en);
    logic [511:0] e;
    @(negedge clk);
    bcast_en = en; lane_sz = 2'(sz); bcast_scalar = {$urandom, $urandom}; src_vec = rnd512();
    #1;
    e = en ? ref_bc(bcast_scalar, sz) : src_vec;
    tests++;
    if (opnd_vec !== e) begin
      fails++;
      $display("FAIL R9: opnd_vec=%h expected %h", opnd_vec, e);
    end
  endtask

  initial begin
    cur = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    op(0, 0, 3); op(3, 1, 7);
    idle(); idle();

    cur = "R2";
    kwrite(1, 64'hA5C3_0F96_1234_8001);
    kwrite(2, 64'h0000_0000_0000_00B6);
    for (int s = 0; s < 4; s++) begin op(s, 0, 1); op(s, 0, 2); end
    cur = "R3";
    for (int s = 0; s < 4; s++) op(s, 0, 1);
    cur = "R4";
    for (int s = 0; s < 4; s++) op(s, 1, 1);
    idle();

    cur = "R5";
    kwrite(0, 64'h0);
    for (int s = 0; s < 4; s++) op(s, 1, 0);
    idle();

    cur = "R6";
    kwrite(3, 64'hFFFF_FFFF_FFFF_FF00);
    op(3, 0, 3); op(3, 1, 3);
    kwrite(4, 64'hFFFF_FFFF_0000_0000);
    op(2, 1, 4); op(2, 0, 4); op(0, 1, 4);
    idle();

    cur = "R7";
    op(1, 0, 1); idle(); idle(); op(2, 1, 2); idle(); op(0, 0, 0); idle(); idle();

    cur = "R8";
    kwrite(5, 64'h0);
    @(negedge clk);
    in_valid = 1; lane_sz = 0; zero_mode = 1; mask_sel = 5;
    result = rnd512(); old_dst = rnd512();
    mk_we = 1; mk_waddr = 5; mk_wdata = 64'hFFFF_0000_FFFF_0000;
    @(negedge clk);
    mk_we = 0; result = rnd512(); old_dst = rnd512();
    idle(); idle();

    cur = "R9";
    for (int s = 0; s < 4; s++) chk_bc(s, 1);
    chk_bc(2, 0); chk_bc(0, 0);
    bcast_en = 0;

    cur = "R2";
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      in_valid = 1'($urandom); lane_sz = 2'($urandom); zero_mode = 1'($urandom);
      mask_sel = 3'($urandom); result = rnd512(); old_dst = rnd512();
      mk_we = 1'($urandom); mk_waddr = 3'($urandom); mk_wdata = {$urandom, $urandom};
    end
    idle(); idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R7: watchdog expired, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule